// File: doc/BRIEF.md
# Memory Channel FIFO Address Sequencer

This block turns a plain RAM region into a streaming buffer for an external bus master. A local CPU programs a start address into the address counter and a stop address into the end register while the channel is disabled. It then sets the enable bit. From that point each completed external access to the memory channel starts one internal RAM cycle at the current counter value. The cycle is a request held until the RAM acknowledges it. After the acknowledge the counter steps by one, so successive external transfers land in successive RAM words.

The transfer stops in one of two ways: an access made at the end address, or an access that carries the terminal-count strobe from an external DMA controller. Each cause sets its own sticky status bit and raises the CPU interrupt. While either bit is set, further external accesses are refused. Both bits and the interrupt clear when the CPU drops the enable bit.

Top module: `mchan_addr_seq`

## Requirements
- R1: After a synchronous reset the enable bit, the address counter, the end register and all status bits read 0, and `ram_req` and `irq` are low.
- R2: Register select codes are 0 = control (bit 0 = enable), 1 = address counter, 2 = end address, 3 = status (bit 0 = request pending, bit 1 = end-address stop, bit 2 = terminal-count stop). `cpu_rdata` shows the selected register in the same cycle. While enable is 0, a write with select 1 or 2 loads that register at the next clock edge.
- R3: While enable is 1, CPU writes to the address counter and to the end register have no effect.
- R4: An `ext_acc` pulse taken while enabled, idle and not stopped raises `ram_req` from the next cycle on, with `ram_addr` equal to the counter. `ram_req` and `ram_addr` stay stable until `ram_ack` is seen.
- R5: `ext_done` is high in the cycle in which `ram_ack` meets a pending request. In that case, with enable still 1 and the counter not at the end address, the counter becomes one higher at that edge.
- R6: An `ext_acc` is ignored while enable is 0, while a request is pending, and after a stop.
- R7: An access completed at the end address leaves the counter at the end address, sets status bit 1 and raises `irq`. The counter never steps past the end address.
- R8: An access started with `ext_tc` high sets status bit 2 and raises `irq` when it completes. The counter still advances for that access unless it sits at the end address, and later accesses are refused.
- R9: Writing enable to 0 clears both stop bits and `irq` one cycle later. Setting enable again resumes streaming.
- R10: A `ram_ack` that arrives with no request pending has no effect.
- R11: If enable is cleared while a request is pending, the request still completes on `ram_ack`, but the counter does not move and no stop bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel | input | 2 | CPU register select |
| cpu_wdata | input | AW | CPU write data |
| cpu_rdata | output | AW | Selected register value |
| ext_acc | input | 1 | One-cycle pulse: external memory-channel access completed |
| ext_tc | input | 1 | Terminal count, qualified by `ext_acc` |
| ext_done | output | 1 | Internal RAM cycle finished; channel ready for the next access |
| ram_req | output | 1 | Internal RAM request |
| ram_ack | input | 1 | Internal RAM acknowledge |
| ram_addr | output | AW | RAM word address |
| irq | output | 1 | Transfer-end interrupt to the CPU |

## Verification
The bench targets several boundaries. The first is the access made exactly at the end address: a design that compares after incrementing stops one word early, and one that skips the compare wraps through the whole RAM. It also sends accesses that overlap a pending request and acknowledges that arrive while idle, because a sequencer that does not ignore these double-steps or drifts the counter. It writes the counter and end registers while enabled, since a missing lock would redirect a transfer in flight. Finally, it drops the enable bit during a pending request, which a design that still updates on the late acknowledge would turn into a phantom increment or a stale stop flag.

// File: rtl/mchan_pkg.sv
// Package: shared encodings for the memory channel address sequencer.
// Assumes the address width is at least 3 so the status bits fit.
package mchan_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_END  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_AEND_BIT  = 1;
    localparam int STAT_TCEND_BIT = 2;
endpackage

// File: rtl/mchan_cfg_regs.sv
// Module: enable bit and end-address register.
// Assumes the write qualifiers (including the enable lock) are decoded by the parent.
module mchan_cfg_regs #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_end,
    input  logic [AW-1:0] wdata,
    output logic          en,
    output logic [AW-1:0] end_addr
);
    import mchan_pkg::*;

    // Purpose: hold the enable bit and the end address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            end_addr <= '0;
        end else begin
            if (wr_ctrl) en <= wdata[CTRL_EN_BIT];
            if (wr_end)  end_addr <= wdata;
        end
    end
endmodule

// File: rtl/mchan_addr_ctr.sv
// Module: loadable FIFO address counter with an end-address compare.
// Assumes load and inc are never high together (the parent guarantees it).
module mchan_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] cnt,
    output logic          at_end
);
    // Purpose: load the start address or step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    // Purpose: address-end detection.
    always_comb at_end = (cnt == end_addr);
endmodule

// File: rtl/mchan_seq.sv
// Module: main sequencer. It accepts one external access at a time, holds
// the RAM request until it is acknowledged, and records the stop causes.
// Assumes ext_acc is a one-cycle pulse and ext_tc is valid with it.
module mchan_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext_acc,
    input  logic ext_tc,
    input  logic ram_ack,
    input  logic at_end,
    output logic ram_req,
    output logic inc,
    output logic done,
    output logic flag_aend,
    output logic flag_tcend,
    output logic busy
);
    import mchan_pkg::*;

    seq_state_e state;
    logic       tc_pend;
    logic       start;
    logic       finish;

    // Purpose: decode the start and finish of a RAM cycle.
    always_comb begin
        start  = (state == ST_IDLE) && en && ext_acc && !flag_aend && !flag_tcend;
        finish = (state == ST_WAIT) && ram_ack;
    end

    // Purpose: the request state and the captured terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tc_pend <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_WAIT;
                    tc_pend <= ext_tc;
                end
                ST_WAIT: if (ram_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: sticky stop flags, cleared while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            flag_aend  <= 1'b0;
            flag_tcend <= 1'b0;
        end else begin
            if (finish && at_end)  flag_aend  <= 1'b1;
            if (finish && tc_pend) flag_tcend <= 1'b1;
        end
    end

    // Purpose: drive the handshake outputs and the counter step.
    always_comb begin
        busy    = (state == ST_WAIT);
        ram_req = busy;
        done    = finish;
        inc     = finish && en && !at_end;
    end
endmodule

// File: rtl/mchan_addr_seq.sv
// Module: top of the memory channel FIFO address sequencer.
// Decodes CPU register access and locks the counter and end register
// while enabled. Assumes AW >= 3.
module mchan_addr_seq #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_sel,
    input  logic [AW-1:0] cpu_wdata,
    output logic [AW-1:0] cpu_rdata,
    input  logic          ext_acc,
    input  logic          ext_tc,
    output logic          ext_done,
    output logic          ram_req,
    input  logic          ram_ack,
    output logic [AW-1:0] ram_addr,
    output logic          irq
);
    import mchan_pkg::*;

    reg_sel_e      sel;
    logic          en_q;
    logic [AW-1:0] end_q;
    logic [AW-1:0] cnt_q;
    logic          at_end;
    logic          wr_ctrl, wr_end, ld_cnt, inc;
    logic          flag_aend, flag_tcend, busy;
    logic [AW-1:0] stat;

    // Purpose: decode the register writes; address and end are locked while enabled.
    always_comb begin
        sel     = reg_sel_e'(cpu_sel);
        wr_ctrl = cpu_wr && (sel == SEL_CTRL);
        wr_end  = cpu_wr && (sel == SEL_END)  && !en_q;
        ld_cnt  = cpu_wr && (sel == SEL_ADDR) && !en_q;
    end

    mchan_cfg_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_end   (wr_end),
        .wdata    (cpu_wdata),
        .en       (en_q),
        .end_addr (end_q)
    );

    mchan_addr_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_cnt),
        .load_val (cpu_wdata),
        .inc      (inc),
        .end_addr (end_q),
        .cnt      (cnt_q),
        .at_end   (at_end)
    );

    mchan_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .ext_acc    (ext_acc),
        .ext_tc     (ext_tc),
        .ram_ack    (ram_ack),
        .at_end     (at_end),
        .ram_req    (ram_req),
        .inc        (inc),
        .done       (ext_done),
        .flag_aend  (flag_aend),
        .flag_tcend (flag_tcend),
        .busy       (busy)
    );

    // Purpose: assemble the status word and the read mux.
    always_comb begin
        stat                 = '0;
        stat[STAT_BUSY_BIT]  = busy;
        stat[STAT_AEND_BIT]  = flag_aend;
        stat[STAT_TCEND_BIT] = flag_tcend;
        case (sel)
            SEL_CTRL: begin
                cpu_rdata              = '0;
                cpu_rdata[CTRL_EN_BIT] = en_q;
            end
            SEL_ADDR: cpu_rdata = cnt_q;
            SEL_END:  cpu_rdata = end_q;
            default:  cpu_rdata = stat;
        endcase
    end

    // Purpose: the RAM address and the interrupt outputs.
    always_comb begin
        ram_addr = cnt_q;
        irq      = flag_aend || flag_tcend;
    end
endmodule

// File: rtl/mchan_addr_seq_chk.sv
// Module: assertion checker bound into mchan_addr_seq.
// Observes the enable bit, counter, end register and handshake.
module mchan_addr_seq_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [AW-1:0] cnt,
    input logic [AW-1:0] end_addr,
    input logic          at_end,
    input logic          flag_aend,
    input logic          irq,
    input logic          ram_req,
    input logic          ram_ack,
    input logic [AW-1:0] ram_addr
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req && !ram_ack |=> ram_req && $stable(ram_addr));

    p_cnt_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && !(ram_req && ram_ack) |=> $stable(cnt));

    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && ram_req && ram_ack && !at_end |=> cnt == $past(cnt) + 1'b1);

    p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && flag_aend |-> cnt == end_addr);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

    p_no_req_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !ram_req |=> !ram_req);
endmodule

bind mchan_addr_seq mchan_addr_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .cnt       (cnt_q),
    .end_addr  (end_q),
    .at_end    (at_end),
    .flag_aend (flag_aend),
    .irq       (irq),
    .ram_req   (ram_req),
    .ram_ack   (ram_ack),
    .ram_addr  (ram_addr)
);

// File: tb/mchan_addr_seq_bench.sv
module mchan_addr_seq_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [1:0]    cpu_sel = 2'd0;
    logic [AW-1:0] cpu_wdata = '0;
    logic [AW-1:0] cpu_rdata;
    logic          ext_acc = 1'b0;
    logic          ext_tc = 1'b0;
    logic          ext_done;
    logic          ram_req;
    logic          ram_ack = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int ack_lat = 0;
    int req_age = 0;
    bit force_ack = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    bit            m_en, m_busy, m_tcp, m_fa, m_ft;
    logic [AW-1:0] m_cnt, m_end;

    always #4 clk = ~clk;

    mchan_addr_seq #(.AW(AW)) u_mchan_addr_seq (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_acc(ext_acc),
        .ext_tc(ext_tc), .ext_done(ext_done), .ram_req(ram_req),
        .ram_ack(ram_ack), .ram_addr(ram_addr), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 0; m_busy <= 0; m_tcp <= 0; m_fa <= 0; m_ft <= 0;
            m_cnt <= '0; m_end <= '0;
        end else begin
            if (cpu_wr) begin
                if (cpu_sel == 2'd0) m_en <= cpu_wdata[0];
                if (cpu_sel == 2'd1 && !m_en) m_cnt <= cpu_wdata;
                if (cpu_sel == 2'd2 && !m_en) m_end <= cpu_wdata;
            end
            if (!m_en) begin
                m_fa <= 0; m_ft <= 0;
            end
            if (m_busy) begin
                if (ram_ack) begin
                    m_busy <= 0;
                    if (m_en) begin
                        if (m_cnt == m_end) m_fa <= 1;
                        else m_cnt <= m_cnt + 1'b1;
                        if (m_tcp) m_ft <= 1;
                    end
                end
            end else if (m_en && ext_acc && !m_fa && !m_ft) begin
                m_busy <= 1;
                m_tcp  <= ext_tc;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [AW-1:0] exp_rd;
            case (cpu_sel)
                2'd0: exp_rd = {{(AW-1){1'b0}}, m_en};
                2'd1: exp_rd = m_cnt;
                2'd2: exp_rd = m_end;
                default: exp_rd = {{(AW-3){1'b0}}, m_ft, m_fa, m_busy};
            endcase
            chk("R4 ram_req", int'(ram_req), int'(m_busy));
            chk("R4 ram_addr", int'(ram_addr), int'(m_cnt));
            chk("R5 ext_done", int'(ext_done), int'(m_busy && ram_ack));
            chk("R7 irq", int'(irq), int'(m_fa || m_ft));
            chk("R2 cpu_rdata", int'(cpu_rdata), int'(exp_rd));
        end
    end

    // RAM responder with programmable latency
    always @(posedge clk) begin
        #2;
        if (ram_req) begin
            ram_ack = (req_age >= ack_lat);
            req_age++;
        end else begin
            req_age = 0;
            ram_ack = force_ack;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(int sel, int val);
        @(posedge clk); #2;
        cpu_wr = 1'b1; cpu_sel = 2'(sel); cpu_wdata = AW'(val);
        @(posedge clk); #2;
        cpu_wr = 1'b0;
    endtask

    task automatic rd(int sel, output int val);
        @(posedge clk); #2;
        cpu_sel = 2'(sel);
        @(negedge clk);
        val = int'(cpu_rdata);
    endtask

    task automatic acc(bit tc, int lat);
        ack_lat = lat;
        @(posedge clk); #2;
        ext_acc = 1'b1; ext_tc = tc;
        @(posedge clk); #2;
        ext_acc = 1'b0; ext_tc = 1'b0;
        cyc(lat + 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(s, v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 ram_req", int'(ram_req), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 load while disabled
        wr(1, 5); wr(2, 8);
        rd(1, v); chk("R2 counter load", v, 5);
        rd(2, v); chk("R2 end load", v, 8);

        // R3 locked while enabled
        wr(0, 1);
        wr(1, 100); wr(2, 3);
        rd(1, v); chk("R3 counter write ignored", v, 5);
        rd(2, v); chk("R3 end write ignored", v, 8);

        // R4/R5 single access, latency 2
        acc(1'b0, 2);
        rd(1, v); chk("R5 counter step", v, 6);

        // R6 overlapping access while pending
        ack_lat = 3;
        @(posedge clk); #2; ext_acc = 1'b1;
        @(posedge clk); #2; ext_acc = 1'b1;
        @(posedge clk); #2; ext_acc = 1'b0;
        cyc(6);
        rd(1, v); chk("R6 access while pending ignored", v, 7);

        // R7 reach end address 8
        acc(1'b0, 0);
        acc(1'b0, 1);
        rd(1, v); chk("R7 counter holds at end", v, 8);
        rd(3, v); chk("R7 end status", v, 2);
        chk("R7 irq raised", int'(irq), 1);
        acc(1'b0, 0);
        rd(1, v); chk("R6 access after stop ignored", v, 8);

        // R9 disable clears status
        wr(0, 0);
        cyc(1);
        chk("R9 irq cleared", int'(irq), 0);
        rd(3, v); chk("R9 status cleared", v, 0);
        acc(1'b0, 0);
        chk("R6 access while disabled no request", int'(ram_req), 0);

        // R8 terminal count
        wr(1, 20); wr(2, 30); wr(0, 1);
        acc(1'b1, 1);
        rd(1, v); chk("R8 counter advanced", v, 21);
        rd(3, v); chk("R8 tc status", v, 4);
        acc(1'b0, 0);
        rd(1, v); chk("R8 later access refused", v, 21);

        // R9 resume after re-enable
        wr(0, 0); wr(0, 1);
        acc(1'b0, 0);
        rd(1, v); chk("R9 resume", v, 22);

        // R10 stray acknowledge
        @(posedge clk); #2; force_ack = 1'b1;
        cyc(2); force_ack = 1'b0;
        cyc(2);
        rd(1, v); chk("R10 stray ack ignored", v, 22);

        // R11 disable during pending request
        ack_lat = 6;
        @(posedge clk); #2; ext_acc = 1'b1;
        @(posedge clk); #2; ext_acc = 1'b0;
        cpu_wr = 1'b1; cpu_sel = 2'd0; cpu_wdata = '0;
        @(posedge clk); #2; cpu_wr = 1'b0;
        cyc(10);
        rd(1, v); chk("R11 no step after disable", v, 22);
        rd(3, v); chk("R11 no status", v, 0);

        // R7 top of the address space, no wrap
        wr(1, 2046); wr(2, 2047); wr(0, 1);
        acc(1'b0, 0);
        acc(1'b0, 0);
        rd(1, v); chk("R7 no wrap at top", v, 2047);
        acc(1'b0, 0);
        rd(1, v); chk("R7 still at top", v, 2047);

        cyc(4);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule